// File: doc/BRIEF.md
# Infrared NEC-Style Pulse Train Transmitter

This block drives one infrared output line with an NEC-style remote-control pulse train. Every phase length is a programmable number of microseconds. A clock prescaler turns the system clock into a one-microsecond tick, and every phase of the train is counted in those ticks. A frame has four parts in this order: a leader made of an active burst and an idle pause, 32 data bits, and a short stop burst. Each data bit is a burst of one shared length followed by a pause whose length depends on the bit value. After the first frame, the block can send a programmed number of further frames. These are either short repeat codes (leader burst, repeat pause, stop burst) or exact copies of the full frame. The frames are spaced by a programmable start-to-start period.

Firmware writes the durations, the 32-bit code word, the idle level, the repeat count, the repeat style and the frame period through a simple write port. It then sets the enable bit. The block takes a copy of all settings at the rising edge of enable and transmits from that copy. When the last frame's stop burst ends, it pulses an end interrupt for one cycle and sets a sticky done flag. Writing a 1 to the status address clears the flag. Clearing enable in the middle of a transmission abandons it at once.

The sequencer states are ST_IDLE, ST_LEAD_LO, ST_LEAD_HI, ST_RPT_HI, ST_BIT_LO, ST_BIT_HI, ST_STOP_LO, ST_GAP and ST_DONE. The transitions are:
- ST_IDLE goes to ST_LEAD_LO on an enable rise.
- ST_LEAD_LO goes to ST_LEAD_HI, or to ST_RPT_HI when the frame is a short repeat.
- ST_LEAD_HI goes to ST_BIT_LO.
- ST_BIT_LO goes to ST_BIT_HI.
- ST_BIT_HI goes back to ST_BIT_LO, or to ST_STOP_LO after bit 31.
- ST_RPT_HI goes to ST_STOP_LO.
- ST_STOP_LO goes to ST_DONE after the last frame. Otherwise it goes to ST_LEAD_LO if the period has already elapsed, or to ST_GAP if it has not.
- ST_GAP goes to ST_LEAD_LO once the period has elapsed.
- ST_DONE goes to ST_IDLE after one cycle.
- Every active state except ST_DONE falls back to ST_IDLE when enable is low.

Top module: `ir_nec_tx`

## Requirements
- R1: A phase programmed to d microseconds (d at least 1) holds the output for exactly d × CLK_DIV clock cycles.
- R2: A full frame sends the following, in order: a leader burst of the leader-low length, a leader pause of the leader-high length, 32 bits, and a stop burst of the bit-low length. Each bit is a bit-low burst followed by a pause of the zero-high length for a 0 bit or the one-high length for a 1 bit.
- R3: The code word is sent one byte at a time in this byte order: bits 31:24, 23:16, 15:8, 7:0. Within each byte, the least significant bit goes first.
- R4: A repeat count N sends N further frames after the first one. With the repeat style at 0, each further frame is a leader burst, then a pause of the repeat-high length, then a stop burst. With the repeat style at 1, each further frame is a full frame.
- R5: The time from the start of one frame to the start of the next is the larger of two values: the frame period and the frame's own length, both in microseconds. When the frame is longer than the period, the next leader follows the stop burst directly.
- R6: Bursts (leader-low, bit-low, stop) drive the inverse of the idle level. Pauses and gaps drive the idle level. While idle, the output follows the live idle-level setting. During a transmission, it uses the copy taken at start.
- R7: The cycle after the final stop burst ends, tx_irq is high for exactly one cycle and tx_done becomes 1. A status write with bit 0 set clears tx_done. A status write with bit 0 clear leaves tx_done unchanged. If a set and a clear happen in the same cycle, the set wins.
- R8: If enable is cleared during a transmission, the output is back at the idle level and tx_busy is low within two cycles of the write. No interrupt is raised and tx_done stays unchanged.
- R9: All settings are copied when enable rises. Writes made during a transmission change nothing until the next start.
- R10: tx_busy goes high on the second clock edge after the write that sets enable and stays high until the sequencer returns to idle.
- R11: Write address map. The data field bits each register uses are listed with it.
  - 0: leader-low [15:0] and leader-high [31:16].
  - 1: repeat-high [15:0].
  - 2: bit-low [15:0].
  - 3: zero-high [15:0] and one-high [31:16].
  - 4: code word [31:0].
  - 5: control. Enable [0], idle level [1], repeat style [2], repeat count [31:16].
  - 6: frame period [17:0].
  - 7: status. Write 1 to bit 0 to clear tx_done.
- R12: After reset, the output is 0 and tx_busy, tx_irq and tx_done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the settings port |
| cfg_addr | input | 3 | Register address (see R11) |
| cfg_wdata | input | 32 | Write data |
| ir_out | output | 1 | Infrared pulse-train output |
| tx_irq | output | 1 | One-cycle end-of-transmission pulse |
| tx_done | output | 1 | Sticky end-of-transmission flag |
| tx_busy | output | 1 | High while a transmission is in progress |

## Verification
The assertions assume three things about how enable is used:
- Enable stays low long enough for the sequencer to see a fresh rise before each transmission.
- Settings changes that must take effect are written while enable is low.
- The idle level is written in a separate write before enable, so the idle-level check compares the output with a setting that is already stable.

The directed tests follow these rules. Each test programs the settings and the idle level with enable clear, lets the line settle, and only then sets enable. Mid-transmission writes are used only to show that they are ignored.

// File: rtl/ir_nec_pkg.sv
package ir_nec_pkg;

    localparam int DUR_W  = 16;
    localparam int PER_W  = 18;
    localparam int CODE_W = 32;
    localparam int RPT_W  = 16;
    localparam int ADDR_W = 3;
    localparam int BIT_W  = $clog2(CODE_W);

    localparam logic [ADDR_W-1:0] A_LEAD   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RPT    = 3'd1;
    localparam logic [ADDR_W-1:0] A_BITLO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_BITHI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CODE   = 3'd4;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd5;
    localparam logic [ADDR_W-1:0] A_PERIOD = 3'd6;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD_LO,
        ST_LEAD_HI,
        ST_RPT_HI,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_STOP_LO,
        ST_GAP,
        ST_DONE
    } tx_state_t;

    typedef struct packed {
        logic [DUR_W-1:0]  lead_lo;
        logic [DUR_W-1:0]  lead_hi;
        logic [DUR_W-1:0]  rpt_hi;
        logic [DUR_W-1:0]  bit_lo;
        logic [DUR_W-1:0]  zero_hi;
        logic [DUR_W-1:0]  one_hi;
        logic [CODE_W-1:0] code;
        logic              idle_pol;
        logic              full_rpt;
        logic [RPT_W-1:0]  rpt_cnt;
        logic [PER_W-1:0]  period;
    } tx_cfg_t;

endpackage

// File: rtl/ir_nec_cfg.sv
module ir_nec_cfg
    import ir_nec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              capture,
    output tx_cfg_t           shadow,
    output logic              en,
    output logic              idle_live,
    output logic              clr_done
);

    tx_cfg_t live;
    logic    en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live <= '0;
            en_q <= 1'b0;
        end else if (we) begin
            unique case (addr)
                A_LEAD: begin
                    live.lead_lo <= wdata[DUR_W-1:0];
                    live.lead_hi <= wdata[31:16];
                end
                A_RPT:   live.rpt_hi <= wdata[DUR_W-1:0];
                A_BITLO: live.bit_lo <= wdata[DUR_W-1:0];
                A_BITHI: begin
                    live.zero_hi <= wdata[DUR_W-1:0];
                    live.one_hi  <= wdata[31:16];
                end
                A_CODE:  live.code <= wdata[CODE_W-1:0];
                A_CTRL: begin
                    en_q          <= wdata[0];
                    live.idle_pol <= wdata[1];
                    live.full_rpt <= wdata[2];
                    live.rpt_cnt  <= wdata[31:16];
                end
                A_PERIOD: live.period <= wdata[PER_W-1:0];
                default: ;
            endcase
        end
    end

    // copy taken once per transmission, at the enable rise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (capture) begin
            shadow <= live;
        end
    end

    assign en        = en_q;
    assign idle_live = live.idle_pol;
    assign clr_done  = we && (addr == A_STAT) && wdata[0];

    logic unused_hi;
    assign unused_hi = ^wdata[15:3];

endmodule

// File: rtl/ir_nec_tick.sv
module ir_nec_tick #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;

    // counter restarts whenever the sequencer is idle so the first
    // microsecond of a transmission is a full one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/ir_nec_seq.sv
module ir_nec_seq
    import ir_nec_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    tick,
    input  logic    idle_live,
    input  tx_cfg_t cfg,
    output logic    start,
    output logic    run,
    output logic    ir_out,
    output logic    irq,
    output logic    busy
);

    tx_state_t         state, nxt;
    logic              en_d;
    logic [DUR_W-1:0]  ph_cnt;
    logic [DUR_W-1:0]  cur_dur;
    logic [PER_W-1:0]  frm_cnt;
    logic [RPT_W-1:0]  frm_idx;
    logic [BIT_W-1:0]  bit_idx;
    logic [CODE_W-1:0] tx_order;
    logic              phase_end;
    logic              frame_due;
    logic              last_frame;
    logic              rpt_simple;
    logic              cur_bit;
    logic              new_frame;

    // reorder the code word into transmit order: high byte first, LSB first
    for (genvar k = 0; k < CODE_W; k++) begin : g_order
        localparam int SRC = (CODE_W/8 - 1 - k/8) * 8 + (k % 8);
        assign tx_order[k] = cfg.code[SRC];
    end

    assign cur_bit    = tx_order[bit_idx];
    assign start      = en && !en_d && (state == ST_IDLE);
    assign last_frame = (frm_idx == cfg.rpt_cnt);
    assign rpt_simple = (frm_idx != '0) && !cfg.full_rpt;
    assign frame_due  = ({1'b0, frm_cnt} + (PER_W+1)'(1)) >= {1'b0, cfg.period};
    assign phase_end  = tick && (({1'b0, ph_cnt} + (DUR_W+1)'(1)) >= {1'b0, cur_dur});
    assign new_frame  = (nxt == ST_LEAD_LO) && (state != ST_LEAD_LO);

    always_comb begin
        unique case (state)
            ST_LEAD_LO: cur_dur = cfg.lead_lo;
            ST_LEAD_HI: cur_dur = cfg.lead_hi;
            ST_RPT_HI:  cur_dur = cfg.rpt_hi;
            ST_BIT_LO:  cur_dur = cfg.bit_lo;
            ST_STOP_LO: cur_dur = cfg.bit_lo;
            ST_BIT_HI:  cur_dur = cur_bit ? cfg.one_hi : cfg.zero_hi;
            default:    cur_dur = '0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start)     nxt = ST_LEAD_LO;
            ST_LEAD_LO: if (phase_end) nxt = rpt_simple ? ST_RPT_HI : ST_LEAD_HI;
            ST_LEAD_HI: if (phase_end) nxt = ST_BIT_LO;
            ST_RPT_HI:  if (phase_end) nxt = ST_STOP_LO;
            ST_BIT_LO:  if (phase_end) nxt = ST_BIT_HI;
            ST_BIT_HI:  if (phase_end) nxt = (bit_idx == BIT_W'(CODE_W-1)) ? ST_STOP_LO : ST_BIT_LO;
            ST_STOP_LO: if (phase_end) nxt = last_frame ? ST_DONE : (frame_due ? ST_LEAD_LO : ST_GAP);
            ST_GAP:     if (tick && frame_due) nxt = ST_LEAD_LO;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
        if (!en && state != ST_IDLE && state != ST_DONE) begin
            nxt = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // phase, frame and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_d    <= 1'b0;
            ph_cnt  <= '0;
            frm_cnt <= '0;
            frm_idx <= '0;
            bit_idx <= '0;
        end else begin
            en_d <= en;

            if (nxt != state) begin
                ph_cnt <= '0;
            end else if (tick) begin
                ph_cnt <= ph_cnt + 1'b1;
            end

            if (new_frame) begin
                frm_cnt <= '0;
            end else if (tick && frm_cnt != '1) begin
                frm_cnt <= frm_cnt + 1'b1;
            end

            if (state == ST_IDLE) begin
                frm_idx <= '0;
            end else if (new_frame) begin
                frm_idx <= frm_idx + 1'b1;
            end

            if (state != ST_BIT_LO && state != ST_BIT_HI) begin
                bit_idx <= '0;
            end else if (state == ST_BIT_HI && phase_end) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        run  = (state != ST_IDLE);
        busy = (state != ST_IDLE);
        irq  = (state == ST_DONE);
        unique case (state)
            ST_IDLE:    ir_out = idle_live;
            ST_LEAD_LO,
            ST_BIT_LO,
            ST_STOP_LO: ir_out = ~cfg.idle_pol;
            default:    ir_out = cfg.idle_pol;
        endcase
    end

endmodule

// File: rtl/ir_nec_tx.sv
module ir_nec_tx
    import ir_nec_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              ir_out,
    output logic              tx_irq,
    output logic              tx_done,
    output logic              tx_busy
);

    tx_cfg_t shadow;
    logic    cfg_en;
    logic    idle_live;
    logic    clr_done;
    logic    start;
    logic    run;
    logic    tick;
    logic    done_q;

    ir_nec_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .capture   (start),
        .shadow    (shadow),
        .en        (cfg_en),
        .idle_live (idle_live),
        .clr_done  (clr_done)
    );

    ir_nec_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    ir_nec_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .tick      (tick),
        .idle_live (idle_live),
        .cfg       (shadow),
        .start     (start),
        .run       (run),
        .ir_out    (ir_out),
        .irq       (tx_irq),
        .busy      (tx_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (tx_irq) begin
            done_q <= 1'b1;
        end else if (clr_done) begin
            done_q <= 1'b0;
        end
    end

    assign tx_done = done_q;

endmodule

// File: rtl/ir_nec_tx_chk.sv
module ir_nec_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic idle_live,
    input logic ir_out,
    input logic tx_irq,
    input logic tx_done,
    input logic tx_busy
);

    // R7: interrupt lasts a single cycle
    a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    // R7: interrupt leaves the sticky flag set
    a_r7_done_follows_irq: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> tx_done);

    // R8: enable low forces the sequencer idle on the next edge
    a_r8_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !tx_busy);

    // R8: no interrupt after enable was low
    a_r8_abort_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !tx_irq);

    // R6: idle line follows the live idle-level setting
    a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> (ir_out == idle_live));

    // R10: a transmission only begins from an enabled state
    a_r10_busy_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(cfg_en));

endmodule

bind ir_nec_tx ir_nec_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .idle_live (idle_live),
    .ir_out    (ir_out),
    .tx_irq    (tx_irq),
    .tx_done   (tx_done),
    .tx_busy   (tx_busy)
);

// File: tb/ir_nec_tx_tb_top.sv
`timescale 1ns/1ps
module ir_nec_tx_tb_top;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ir_out, tx_irq, tx_done, tx_busy;

    always #2.5 clk = ~clk;

    ir_nec_tx #(.CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ir_out(ir_out), .tx_irq(tx_irq),
        .tx_done(tx_done), .tx_busy(tx_busy)
    );

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    // run-length log of the output line
    logic run_lvl = 1'b0;
    int   run_len = 0;
    logic got_lvl [0:2047];
    int   got_len [0:2047];
    int   n_runs = 0;
    int   irq_cnt = 0;

    logic exp_lvl [0:1023];
    int   exp_len [0:1023];
    int   n_exp;

    int t_ll, t_lh, t_rh, t_bl, t_h0, t_h1, t_per;
    logic [31:0] t_code;
    int base, irq0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_irq) irq_cnt++;
            if (ir_out !== run_lvl) begin
                if (n_runs < 2048) begin
                    got_lvl[n_runs] = run_lvl;
                    got_len[n_runs] = run_len;
                end
                n_runs++;
                run_lvl = ir_out;
                run_len = 1;
            end else begin
                run_len++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R11 address map used throughout
    task automatic load_times(input int ll, input int lh, input int rh, input int bl,
                              input int h0, input int h1, input logic [31:0] code, input int per);
        t_ll = ll; t_lh = lh; t_rh = rh; t_bl = bl; t_h0 = h0; t_h1 = h1;
        t_code = code; t_per = per;
        wr(3'd0, {lh[15:0], ll[15:0]});
        wr(3'd1, {16'd0, rh[15:0]});
        wr(3'd2, {16'd0, bl[15:0]});
        wr(3'd3, {h1[15:0], h0[15:0]});
        wr(3'd4, code);
        wr(3'd6, {14'd0, per[17:0]});
    endtask

    task automatic set_ctrl(input bit en, input bit pol, input bit full, input int nrep);
        wr(3'd5, {nrep[15:0], 13'd0, full, pol, en});
    endtask

    task automatic start_tx(input bit pol, input bit full, input int nrep);
        set_ctrl(1'b0, pol, full, nrep);
        repeat (3) @(negedge clk);
        base = n_runs;
        irq0 = irq_cnt;
        set_ctrl(1'b1, pol, full, nrep);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (tx_busy && !finished) @(negedge clk);
    endtask

    task automatic add(input logic lvl, input int ticks);
        if (n_exp > 0 && exp_lvl[n_exp-1] == lvl) begin
            exp_len[n_exp-1] += ticks * DIV;
        end else begin
            exp_lvl[n_exp] = lvl;
            exp_len[n_exp] = ticks * DIV;
            n_exp++;
        end
    endtask

    task automatic build(input logic pol, input bit full, input int nrep);
        logic act;
        int content;
        act = ~pol;
        n_exp = 0;
        for (int f = 0; f <= nrep; f++) begin
            add(act, t_ll);
            if (f == 0 || full) begin
                add(~act, t_lh);
                content = t_ll + t_lh + t_bl;
                for (int k = 0; k < 32; k++) begin
                    int idx;
                    int h;
                    idx = (3 - k / 8) * 8 + (k % 8);
                    h = t_code[idx] ? t_h1 : t_h0;
                    add(act, t_bl);
                    add(~act, h);
                    content += t_bl + h;
                end
            end else begin
                add(~act, t_rh);
                content = t_ll + t_rh + t_bl;
            end
            add(act, t_bl);
            if (f < nrep && t_per > content) add(~act, t_per - content);
        end
    endtask

    task automatic compare(input string req);
        int bad;
        int first;
        bad = 0; first = -1;
        while (n_runs < base + 1 + n_exp && !finished) @(negedge clk);
        for (int i = 0; i < n_exp; i++) begin
            if (got_lvl[base+1+i] !== exp_lvl[i] || got_len[base+1+i] != exp_len[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) first = 0;
        chk(bad == 0, req, $sformatf("pulse train run %0d length", first),
            got_len[base+1+first], exp_len[first]);
    endtask

    task automatic test_reset();
        chk(ir_out == 1'b0, "R12", "ir_out after reset", ir_out, 0);
        chk(tx_busy == 1'b0, "R12", "tx_busy after reset", tx_busy, 0);
        chk(tx_done == 1'b0, "R12", "tx_done after reset", tx_done, 0);
        chk(tx_irq == 1'b0, "R12", "tx_irq after reset", tx_irq, 0);
    endtask

    task automatic test_full_frame();
        load_times(9, 5, 3, 1, 1, 3, 32'h5AA5_3CC3, 200);
        start_tx(1'b1, 1'b0, 0);
        repeat (2) @(negedge clk);
        chk(tx_busy == 1'b1, "R10", "busy after enable", tx_busy, 1);
        repeat (100) @(negedge clk);
        // R9: these writes land mid-frame and must not change it
        wr(3'd0, {16'd40, 16'd40});
        wr(3'd4, 32'h0000_0000);
        wait_idle();
        build(1'b1, 1'b0, 0);
        compare("R2/R3/R9");
        chk(got_len[base+1] == 9 * DIV, "R1", "leader burst cycles", got_len[base+1], 9 * DIV);
        chk(irq_cnt - irq0 == 1, "R7", "irq pulses", irq_cnt - irq0, 1);
        chk(tx_done == 1'b1, "R7", "done flag set", tx_done, 1);
    endtask

    task automatic test_status();
        wr(3'd7, 32'h0);
        @(negedge clk);
        chk(tx_done == 1'b1, "R7", "status write of 0 keeps done", tx_done, 1);
        wr(3'd7, 32'h1);
        @(negedge clk);
        chk(tx_done == 1'b0, "R11", "status write of 1 clears done", tx_done, 0);
    endtask

    task automatic test_simple_repeat();
        load_times(9, 5, 3, 1, 1, 3, 32'h5AA5_3CC3, 150);
        start_tx(1'b1, 1'b0, 2);
        wait_idle();
        build(1'b1, 1'b0, 2);
        compare("R4/R5 simple");
        chk(irq_cnt - irq0 == 1, "R7", "irq pulses after repeats", irq_cnt - irq0, 1);
    endtask

    task automatic test_full_repeat();
        load_times(9, 5, 3, 1, 1, 3, 32'hA35C_0FF0, 50);
        start_tx(1'b1, 1'b1, 1);
        wait_idle();
        build(1'b1, 1'b1, 1);
        compare("R4/R5 full, no gap");
        chk(tx_done == 1'b1, "R7", "done after full repeats", tx_done, 1);
    endtask

    task automatic test_pol_low();
        load_times(7, 4, 3, 2, 1, 3, 32'h01FE_807F, 200);
        set_ctrl(1'b0, 1'b0, 1'b0, 0);
        repeat (2) @(negedge clk);
        chk(ir_out == 1'b0, "R6", "idle level follows setting", ir_out, 0);
        start_tx(1'b0, 1'b0, 0);
        wait_idle();
        build(1'b0, 1'b0, 0);
        compare("R6 inverted train");
    endtask

    task automatic test_abort();
        wr(3'd7, 32'h1);
        load_times(9, 5, 3, 1, 1, 3, 32'h5AA5_3CC3, 200);
        start_tx(1'b1, 1'b0, 0);
        repeat (100) @(negedge clk);
        set_ctrl(1'b0, 1'b1, 1'b0, 0);
        repeat (2) @(negedge clk);
        chk(ir_out == 1'b1, "R8", "line idle after abort", ir_out, 1);
        chk(tx_busy == 1'b0, "R8", "busy low after abort", tx_busy, 0);
        repeat (600) @(negedge clk);
        chk(irq_cnt - irq0 == 0, "R8", "no irq on abort", irq_cnt - irq0, 0);
        chk(tx_done == 1'b0, "R8", "done clear on abort", tx_done, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run did not complete", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_full_frame();
        test_status();
        set_ctrl(1'b0, 1'b1, 1'b0, 0);
        test_simple_repeat();
        test_full_repeat();
        test_pol_low();
        test_abort();
        finish_run();
    end

endmodule